// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control section of a simple processor built around stored microcode. A control address register selects one word of an on-chip control store. The store is filled from a packed parameter image at elaboration. On each clock the selected word is latched into a control buffer register, which drives the processor's control lines for one cycle.

Each word holds four parts: a control-line field, two flag-capture enables, a 3-bit condition select and a branch address. At each clock the sequencer picks the next control address from the word currently being read. It either steps by one, or takes the branch address when the selected condition holds, or jumps to the start of the routine for the current machine opcode through a fixed opcode map.

Two one-bit flags can be loaded by microcode from the sign bits of two datapath registers. Later words can then test these flags. A build option replaces the one-bit-per-line field with a compact action code, and a decoder after the buffer expands that code into a single line.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_ni is low, the control address is 0, both flags are 0 and every control line is low. The first word presented after reset is released is the word at address 0.
- R2: lines_o carries the line field of the word addressed in the previous cycle, and only for one cycle. In the horizontal form, a 1 in field bit k asserts line k and a 0 keeps it low.
- R3: Select codes 0 (never) and 7 (reserved) make the next address the current address plus one, wrapping at the top of the store.
- R4: Select code 1 loads the branch address unconditionally.
- R5: Select code 2 tests zero_i and select code 3 tests neg_i, both sampled in the cycle the word is addressed. When the tested input is true the branch address is loaded; otherwise the address steps by one.
- R6: Select code 6 loads MAP_BASE + opcode_i * 2^MAP_SHIFT, which with the default parameters is 8 + 4*opcode_i.
- R7: When capture-enable bit k of a word is set, flag k takes sign_src_i[k] at the edge that latches that word; otherwise the flag holds its value. Select codes 4 and 5 test flag 0 and flag 1 and branch when the flag is 1. The word that directly follows a capturing word already sees the new value.
- R8: Horizontal word layout, counted from bit 0: bits [4:0] hold the branch address, [7:5] the condition select, bit 8 the capture enable for flag 0, bit 9 the capture enable for flag 1, and [17:10] the line field.
- R9: With VERTICAL set, bits [13:10] hold an action code. Code 0 asserts no line, and code k (1 to 8) asserts line k-1 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 2 | Opcode of the current machine instruction, used by dispatch |
| zero_i | input | 1 | ALU zero flag |
| neg_i | input | 1 | ALU sign flag |
| sign_src_i | input | 2 | Sign bits of two datapath registers, used for flag capture |
| lines_o | output | 8 | Control lines from the control buffer register |

## Verification
The assertions assume that opcode_i, zero_i, neg_i and sign_src_i are steady around each rising edge. They also assume that the packed image matches the layout of the chosen field form. The bench changes inputs only on falling edges and builds both images itself from the R8 and R9 layouts.

The bench draws inputs at random on every cycle, so that each conditional word is met with its condition both true and false. It also pulses reset in the middle of the run to check the return to address 0.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UC_ADDR_W = 5;
  localparam int UC_LINES  = 8;
  localparam int UC_OPC_W  = 2;
  localparam int UC_WORD_W = UC_LINES + 2 + 3 + UC_ADDR_W;
  localparam int UC_DEPTH  = 2 ** UC_ADDR_W;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_JUMP = 3'd1,
    SEL_ZERO = 3'd2,
    SEL_NEG  = 3'd3,
    SEL_F0   = 3'd4,
    SEL_F1   = 3'd5,
    SEL_MAP  = 3'd6,
    SEL_RSV  = 3'd7
  } sel_e;

  function automatic logic [UC_WORD_W-1:0] uw(input logic [UC_LINES-1:0] l,
                                               input logic [1:0] s,
                                               input sel_e c,
                                               input logic [UC_ADDR_W-1:0] a);
    return {l, s, c, a};
  endfunction

  // fetch at 0..4 ending in dispatch; one stub routine per opcode
  function automatic logic [UC_DEPTH*UC_WORD_W-1:0] default_ucode();
    logic [UC_DEPTH*UC_WORD_W-1:0] img;
    logic [UC_WORD_W-1:0] w;
    img = '0;
    for (int i = 0; i < UC_DEPTH; i++) begin
      case (i)
        0:       w = uw(8'h01, 2'b00, SEL_NONE, 5'd0);
        1:       w = uw(8'h06, 2'b00, SEL_NONE, 5'd0);
        2:       w = uw(8'h08, 2'b00, SEL_NONE, 5'd0);
        3:       w = uw(8'h10, 2'b00, SEL_NONE, 5'd0);
        4:       w = uw(8'h00, 2'b00, SEL_MAP,  5'd0);
        8:       w = uw(8'h20, 2'b00, SEL_JUMP, 5'd0);
        12:      w = uw(8'h40, 2'b00, SEL_JUMP, 5'd0);
        16:      w = uw(8'h80, 2'b00, SEL_JUMP, 5'd0);
        20:      w = uw(8'hC0, 2'b00, SEL_JUMP, 5'd0);
        default: w = uw(8'h00, 2'b00, SEL_JUMP, 5'd0);
      endcase
      img[i*UC_WORD_W +: UC_WORD_W] = w;
    end
    return img;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 18,
  parameter logic [(2**ADDR_W)*WORD_W-1:0] IMAGE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign tbl[g] = IMAGE[g*WORD_W +: WORD_W];
  end

  assign word_o = tbl[addr_i];
endmodule

// File: rtl/useq_map.sv
module useq_map #(
  parameter int OPC_W     = 2,
  parameter int ADDR_W    = 5,
  parameter int MAP_BASE  = 8,
  parameter int MAP_SHIFT = 2
) (
  input  logic [OPC_W-1:0]  opcode_i,
  output logic [ADDR_W-1:0] start_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(MAP_BASE);

  assign start_o = BASE + (ADDR_W'(opcode_i) << MAP_SHIFT);
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] car_i,
  input  sel_e              sel_i,
  input  logic [ADDR_W-1:0] branch_i,
  input  logic [ADDR_W-1:0] map_i,
  input  logic              zero_i,
  input  logic              neg_i,
  input  logic [1:0]        flag_i,
  output logic [ADDR_W-1:0] next_o
);
  logic taken;

  always_comb begin
    unique case (sel_i)
      SEL_JUMP: taken = 1'b1;
      SEL_ZERO: taken = zero_i;
      SEL_NEG:  taken = neg_i;
      SEL_F0:   taken = flag_i[0];
      SEL_F1:   taken = flag_i[1];
      default:  taken = 1'b0;
    endcase
  end

  always_comb begin
    if (sel_i == SEL_MAP) next_o = map_i;
    else if (taken)       next_o = branch_i;
    else                  next_o = car_i + 1'b1;
  end
endmodule

// File: rtl/useq_lines.sv
module useq_lines #(
  parameter int N_LINES  = 8,
  parameter int FIELD_W  = 8,
  parameter bit VERTICAL = 1'b0
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [N_LINES-1:0] lines_o
);
  if (VERTICAL) begin : g_vert
    for (genvar k = 0; k < N_LINES; k++) begin : g_dec
      assign lines_o[k] = (field_i == FIELD_W'(k + 1));
    end
  end else begin : g_horz
    assign lines_o = N_LINES'(field_i);
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int ADDR_W    = UC_ADDR_W,
  parameter int N_LINES   = UC_LINES,
  parameter int OPC_W     = UC_OPC_W,
  parameter bit VERTICAL  = 1'b0,
  parameter int MAP_BASE  = 8,
  parameter int MAP_SHIFT = 2,
  parameter logic [(2**ADDR_W)*((VERTICAL ? $clog2(N_LINES+1) : N_LINES)+5+ADDR_W)-1:0]
    UCODE = default_ucode()
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic               zero_i,
  input  logic               neg_i,
  input  logic [1:0]         sign_src_i,
  output logic [N_LINES-1:0] lines_o
);
  localparam int FIELD_W   = VERTICAL ? $clog2(N_LINES + 1) : N_LINES;
  localparam int SEL_LSB   = ADDR_W;
  localparam int SET_LSB   = ADDR_W + 3;
  localparam int FIELD_LSB = ADDR_W + 5;
  localparam int WORD_W    = FIELD_LSB + FIELD_W;

  logic [ADDR_W-1:0]  car_q, car_d;
  logic [WORD_W-1:0]  word;
  logic [ADDR_W-1:0]  baddr, map_addr;
  sel_e               sel;
  logic [1:0]         setf;
  logic [FIELD_W-1:0] field, field_q;
  logic [1:0]         flag_q;

  useq_rom #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .IMAGE(UCODE)) u_rom (
    .addr_i (car_q),
    .word_o (word)
  );

  assign baddr = word[ADDR_W-1:0];
  assign sel   = sel_e'(word[SEL_LSB +: 3]);
  assign setf  = word[SET_LSB +: 2];
  assign field = word[FIELD_LSB +: FIELD_W];

  useq_map #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE),
             .MAP_SHIFT(MAP_SHIFT)) u_map (
    .opcode_i (opcode_i),
    .start_o  (map_addr)
  );

  // next address decided from the word being read, so no delay slot
  useq_next #(.ADDR_W(ADDR_W)) u_next (
    .car_i    (car_q),
    .sel_i    (sel),
    .branch_i (baddr),
    .map_i    (map_addr),
    .zero_i   (zero_i),
    .neg_i    (neg_i),
    .flag_i   (flag_q),
    .next_o   (car_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q   <= '0;
      field_q <= '0;
    end else begin
      car_q   <= car_d;
      field_q <= field;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q[k] <= 1'b0;
      else if (setf[k]) flag_q[k] <= sign_src_i[k];
    end
  end

  useq_lines #(.N_LINES(N_LINES), .FIELD_W(FIELD_W), .VERTICAL(VERTICAL)) u_lines (
    .field_i (field_q),
    .lines_o (lines_o)
  );

  // R2
  buf_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> field_q == $past(field));

  // R3
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE || sel == SEL_RSV) |=> car_q == ADDR_W'($past(car_q) + 1'b1));

  // R4
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel == SEL_JUMP |=> car_q == $past(baddr));

  // R5
  zero_false_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_ZERO && !zero_i) |=> car_q == ADDR_W'($past(car_q) + 1'b1));

  // R6
  dispatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel == SEL_MAP |=> car_q == ADDR_W'(MAP_BASE + int'($past(opcode_i)) * (2 ** MAP_SHIFT)));

  // R7
  flag_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setf[0] |=> flag_q[0] == $past(sign_src_i[0]));

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setf[1] |=> $stable(flag_q[1]));

  if (VERTICAL) begin : g_vchk
    // R9
    one_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(lines_o));
  end
endmodule

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DEPTH = 32;
  localparam int HW = 18;
  localparam int VW = 14;
  localparam int RUN = 3000;

  // prog bits: [4:0] branch, [7:5] select, [9:8] capture, [13:10] vcode, [21:14] hlines
  function automatic logic [21:0] mk(input logic [7:0] hl, input logic [3:0] vc,
                                     input logic [1:0] s, input logic [2:0] c,
                                     input logic [4:0] a);
    return {hl, vc, s, c, a};
  endfunction

  function automatic logic [21:0] prog(input int a);
    case (a)
      0:  return mk(8'h01, 4'd1, 2'b00, 3'd0, 5'd0);
      1:  return mk(8'h03, 4'd2, 2'b00, 3'd0, 5'd0);
      2:  return mk(8'h06, 4'd3, 2'b00, 3'd0, 5'd0);
      3:  return mk(8'h0C, 4'd4, 2'b00, 3'd0, 5'd0);
      4:  return mk(8'h18, 4'd5, 2'b00, 3'd6, 5'd0);
      8:  return mk(8'h21, 4'd6, 2'b00, 3'd2, 5'd11);
      9:  return mk(8'h22, 4'd7, 2'b00, 3'd7, 5'd0);
      10: return mk(8'h24, 4'd8, 2'b00, 3'd1, 5'd0);
      11: return mk(8'h28, 4'd1, 2'b00, 3'd1, 5'd0);
      12: return mk(8'h41, 4'd2, 2'b01, 3'd0, 5'd0);
      13: return mk(8'h42, 4'd3, 2'b00, 3'd4, 5'd15);
      14: return mk(8'h44, 4'd4, 2'b00, 3'd1, 5'd0);
      15: return mk(8'h48, 4'd5, 2'b00, 3'd1, 5'd0);
      16: return mk(8'h81, 4'd6, 2'b00, 3'd3, 5'd18);
      17: return mk(8'h82, 4'd7, 2'b00, 3'd1, 5'd0);
      18: return mk(8'h84, 4'd8, 2'b10, 3'd0, 5'd0);
      19: return mk(8'h88, 4'd0, 2'b00, 3'd5, 5'd0);
      20: return mk(8'hF0, 4'd1, 2'b00, 3'd1, 5'd0);
      default: return mk(8'hEE, 4'd2, 2'b00, 3'd1, 5'd0);
    endcase
  endfunction

  function automatic logic [DEPTH*HW-1:0] img_h();
    logic [DEPTH*HW-1:0] img;
    logic [21:0] p;
    img = '0;
    for (int i = 0; i < DEPTH; i++) begin
      p = prog(i);
      img[i*HW +: HW] = {p[21:14], p[9:0]};
    end
    return img;
  endfunction

  function automatic logic [DEPTH*VW-1:0] img_v();
    logic [DEPTH*VW-1:0] img;
    logic [21:0] p;
    img = '0;
    for (int i = 0; i < DEPTH; i++) begin
      p = prog(i);
      img[i*VW +: VW] = {p[13:10], p[9:0]};
    end
    return img;
  endfunction

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] opcode = '0;
  logic       zero = 1'b0, neg = 1'b0;
  logic [1:0] ssrc = '0;
  logic [7:0] lines_h, lines_v;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_ctrl #(.VERTICAL(1'b0), .UCODE(img_h())) u0 (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .zero_i(zero), .neg_i(neg),
    .sign_src_i(ssrc), .lines_o(lines_h)
  );

  useq_ctrl #(.VERTICAL(1'b1), .UCODE(img_v())) u1 (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .zero_i(zero), .neg_i(neg),
    .sign_src_i(ssrc), .lines_o(lines_v)
  );

  // behavioural reference
  int    m_car, m_cbr;
  bit    m_full;
  bit [1:0] m_flag;
  string rule_car, rule_cbr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_car = 0; m_cbr = 0; m_full = 0; m_flag = 2'b00;
      rule_car = "R1"; rule_cbr = "R1";
    end else begin
      logic [21:0] p;
      bit taken;
      int nxt;
      string r;
      p = prog(m_car);
      taken = 0;
      case (int'(p[7:5]))
        1: begin taken = 1; r = "R4"; end
        2: begin taken = zero; r = "R5"; end
        3: begin taken = neg; r = "R5"; end
        4: begin taken = m_flag[0]; r = "R7"; end
        5: begin taken = m_flag[1]; r = "R7"; end
        6: begin taken = 1; r = "R6"; end
        default: begin taken = 0; r = "R3"; end
      endcase
      if (int'(p[7:5]) == 6) nxt = 8 + 4 * int'(opcode);
      else if (taken)        nxt = int'(p[4:0]);
      else                   nxt = (m_car + 1) % DEPTH;
      if (p[8]) m_flag[0] = ssrc[0];
      if (p[9]) m_flag[1] = ssrc[1];
      m_cbr = m_car; m_full = 1;
      rule_cbr = rule_car; rule_car = r;
      m_car = nxt;
    end
  end

  task automatic compare();
    logic [21:0] p;
    logic [7:0] eh, ev;
    p = prog(m_cbr);
    eh = m_full ? p[21:14] : 8'h00;
    ev = (m_full && p[13:10] != 0) ? 8'(1 << (int'(p[13:10]) - 1)) : 8'h00;
    compared++;
    if (lines_h !== eh) begin
      mismatched++;
      $display("FAIL R2 R8 %s horizontal lines: actual %h expected %h (word %0d)",
               m_full ? rule_cbr : "R1", lines_h, eh, m_cbr);
    end
    compared++;
    if (lines_v !== ev) begin
      mismatched++;
      $display("FAIL R9 %s vertical lines: actual %h expected %h (word %0d)",
               m_full ? rule_cbr : "R1", lines_v, ev, m_cbr);
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      compare(); // R1 lines low in reset
    end
    rst_n = 1'b1;
    for (int i = 0; i < RUN; i++) begin
      @(negedge clk);
      compare();
      if (i == RUN/2 || i == RUN/2 + 1) rst_n = 1'b0; // R1 mid-run reset
      else rst_n = 1'b1;
      opcode = 2'($urandom);
      zero   = 1'($urandom);
      neg    = 1'($urandom);
      ssrc   = 2'($urandom);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL R1 watchdog: actual run still active, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule